// File: doc/BRIEF.md
# Accumulator ALU Execute Unit

This block executes the register-operand instructions of a small 8-bit controller. It has 13-bit instruction words, one accumulator and a 64-byte register file. Each accepted instruction is decoded in one step. The selected register is read without a clock delay. The result is written at the next clock edge into the accumulator or back into the register. The zero, carry and half-carry flags are updated according to the operation.

The decrement-and-test forms can ask for the following instruction to be skipped. When that happens, the block raises a one-cycle skip indication and discards whatever instruction arrives in the next slot. A skipping instruction therefore occupies two slots. Opcodes outside the supported set are accepted as no-operations.

A read-only observation port returns any register's contents without a clock delay. An enclosing pipeline uses the valid and skip outputs to keep its program flow aligned.

Top module: `acc_alu_core`

## Requirements
- R1: While rst_ni is low, acc_o, z_o, c_o, dc_o, valid_o and skip_next_o are 0, and every register reads 0.
- R2: The instruction splits into the group [12:8], the sub-op [7:6] and the register address [5:0]. In groups 1 to 5, bit 6 = 0 writes the result to the accumulator and bit 6 = 1 writes it to the addressed register.
- R3: 0x040|r copies the accumulator to register r and leaves all flags unchanged. 0x080 clears the accumulator and 0x0C0|r clears register r; both set Z and leave C and DC unchanged.
- R4: Group 1 with sub-op 0 or 1 computes R minus A. C is set when R >= A, DC is set when R[3:0] >= A[3:0], and Z is updated.
- R5: Group 3 with sub-op 2 or 3 computes A plus R. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is updated.
- R6: OR (group 2, sub-op 0/1), AND (group 2, sub-op 2/3) and XOR (group 3, sub-op 0/1) update only Z.
- R7: The following update only Z: decrement (group 1, sub-op 2/3), move R (group 4, sub-op 0/1; sub-op 1 writes R back to itself as a zero test), complement R (group 4, sub-op 2/3) and increment (group 5, sub-op 0/1).
- R8: Group 5 with sub-op 2 or 3 writes R minus 1 and leaves all flags unchanged. When the result is zero, skip_next_o is high for exactly one cycle and the instruction presented in the next slot changes no state and raises no valid_o.
- R9: 0x600|r loads {C, R[7:1]} into the accumulator and R[0] into C, leaving Z and DC unchanged.
- R10: Any other opcode, for example 0x000, 0x081–0x0BF, 0x640 or group 7, changes neither the accumulator, nor the flags, nor any register.
- R11: valid_o is high in the cycle after each accepted, non-skipped instruction and low otherwise. With no instruction accepted, the accumulator and flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction present this slot |
| instr_i | input | 13 | Instruction word |
| dbg_addr_i | input | 6 | Observation port register address |
| acc_o | output | 8 | Accumulator |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry / no-borrow flag |
| dc_o | output | 1 | Half-carry / half no-borrow flag |
| valid_o | output | 1 | Previous slot executed an instruction |
| skip_next_o | output | 1 | Skip taken; the current slot is discarded |
| dbg_data_o | output | 8 | Contents of register dbg_addr_i |

## Verification
The assertions check the following on every cycle:
- the one-cycle length of a skip and the squashed slot after it;
- that valid_o follows each accepted instruction;
- the flags staying unchanged for register moves, decrement-and-test and idle slots;
- the cleared accumulator with Z set;
- the old carry landing in bit 7 on a rotate.

The arithmetic values need the bench's scenarios: subtraction borrow polarity, half-carry on both add and subtract, the zero-test move, and the destination choice per sub-op. So do ignored opcodes that leave registers untouched, the zero-result decrement that still leaves Z alone, and a reset taken in the middle of a run.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_NOP, OP_MOVRA, OP_CLR, OP_SUB, OP_DEC, OP_OR, OP_AND, OP_XOR,
    OP_ADD, OP_MOV, OP_COM, OP_INC, OP_DJZ, OP_RRC
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    wr_acc;
    logic    wr_reg;
    logic    upd_z;
    logic    upd_c;
    logic    upd_dc;
    logic    skip_en;
  } dec_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
#(
  parameter int INSTR_W = 13,
  parameter int ADDR_W  = 6
) (
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  localparam int GRP_LSB = ADDR_W + 2;
  localparam int GRP_W   = INSTR_W - GRP_LSB;

  logic [GRP_W-1:0]  grp;
  logic [1:0]        sub;
  logic [ADDR_W-1:0] addr;
  logic              to_reg;

  assign grp    = instr_i[INSTR_W-1:GRP_LSB];
  assign sub    = instr_i[GRP_LSB-1:ADDR_W];
  assign addr   = instr_i[ADDR_W-1:0];
  assign to_reg = sub[0];

  always_comb begin
    dec_o    = '0;
    dec_o.op = OP_NOP;
    if (grp == GRP_W'(0)) begin
      if (sub == 2'b01) begin
        dec_o.op     = OP_MOVRA;
        dec_o.wr_reg = 1'b1;
      end else if (sub == 2'b11) begin
        dec_o.op     = OP_CLR;
        dec_o.wr_reg = 1'b1;
        dec_o.upd_z  = 1'b1;
      end else if (sub == 2'b10 && addr == '0) begin
        dec_o.op     = OP_CLR;
        dec_o.wr_acc = 1'b1;
        dec_o.upd_z  = 1'b1;
      end
    end else if (grp >= GRP_W'(1) && grp <= GRP_W'(5)) begin
      dec_o.wr_acc = !to_reg;
      dec_o.wr_reg = to_reg;
      dec_o.upd_z  = 1'b1;
      if (grp == GRP_W'(1)) begin
        dec_o.op = sub[1] ? OP_DEC : OP_SUB;
        dec_o.upd_c  = !sub[1];
        dec_o.upd_dc = !sub[1];
      end else if (grp == GRP_W'(2)) begin
        dec_o.op = sub[1] ? OP_AND : OP_OR;
      end else if (grp == GRP_W'(3)) begin
        dec_o.op = sub[1] ? OP_ADD : OP_XOR;
        dec_o.upd_c  = sub[1];
        dec_o.upd_dc = sub[1];
      end else if (grp == GRP_W'(4)) begin
        dec_o.op = sub[1] ? OP_COM : OP_MOV;
      end else begin
        dec_o.op      = sub[1] ? OP_DJZ : OP_INC;
        dec_o.upd_z   = !sub[1];
        dec_o.skip_en = sub[1];
      end
    end else if (grp == GRP_W'(6) && sub == 2'b00) begin
      dec_o.op     = OP_RRC;
      dec_o.wr_acc = 1'b1;
      dec_o.upd_c  = 1'b1;
    end
  end
endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] r_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              z_o,
  output logic              c_o,
  output logic              dc_o
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W:0] sum_w, dif_w;
  logic [NIB_W:0]  sum_n, dif_n;

  assign sum_w = {1'b0, a_i} + {1'b0, r_i};
  assign dif_w = {1'b0, r_i} - {1'b0, a_i};
  assign sum_n = {1'b0, a_i[NIB_W-1:0]} + {1'b0, r_i[NIB_W-1:0]};
  assign dif_n = {1'b0, r_i[NIB_W-1:0]} - {1'b0, a_i[NIB_W-1:0]};

  always_comb begin
    res_o = a_i;
    c_o   = c_i;
    dc_o  = 1'b0;
    case (op_i)
      OP_MOVRA: res_o = a_i;
      OP_CLR:   res_o = '0;
      OP_SUB: begin
        res_o = dif_w[DATA_W-1:0];
        c_o   = !dif_w[DATA_W];
        dc_o  = !dif_n[NIB_W];
      end
      OP_ADD: begin
        res_o = sum_w[DATA_W-1:0];
        c_o   = sum_w[DATA_W];
        dc_o  = sum_n[NIB_W];
      end
      OP_DEC, OP_DJZ: res_o = r_i - DATA_W'(1);
      OP_INC:  res_o = r_i + DATA_W'(1);
      OP_OR:   res_o = a_i | r_i;
      OP_AND:  res_o = a_i & r_i;
      OP_XOR:  res_o = a_i ^ r_i;
      OP_MOV:  res_o = r_i;
      OP_COM:  res_o = ~r_i;
      OP_RRC: begin
        res_o = {c_i, r_i[DATA_W-1:1]};
        c_o   = r_i[0];
      end
      default: res_o = a_i;
    endcase
  end

  assign z_o = (res_o == '0);
endmodule

// File: rtl/acc_alu_regfile.sv
module acc_alu_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= '0;
      else if (we_i && waddr_i == ADDR_W'(g))      regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o    = regs_q[raddr_i];
  assign dbg_data_o = regs_q[dbg_addr_i];
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int INSTR_W = 13,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  dbg_addr_i,
  output logic [DATA_W-1:0]  acc_o,
  output logic               z_o,
  output logic               c_o,
  output logic               dc_o,
  output logic               valid_o,
  output logic               skip_next_o,
  output logic [DATA_W-1:0]  dbg_data_o
);
  dec_t              dec;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] r_val, res;
  logic              z_new, c_new, dc_new;
  logic              fire, skip_d;
  logic [DATA_W-1:0] acc_q;
  logic              z_q, c_q, dc_q, valid_q, skip_q;

  assign raddr = instr_i[ADDR_W-1:0];
  assign fire  = instr_valid_i && !skip_q;  // slot after a taken skip is dropped

  acc_alu_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) i_decode (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  acc_alu_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (fire && dec.wr_reg),
    .waddr_i    (raddr),
    .wdata_i    (res),
    .raddr_i    (raddr),
    .rdata_o    (r_val),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_data_o)
  );

  acc_alu_datapath #(.DATA_W(DATA_W)) i_datapath (
    .op_i  (dec.op),
    .a_i   (acc_q),
    .r_i   (r_val),
    .c_i   (c_q),
    .res_o (res),
    .z_o   (z_new),
    .c_o   (c_new),
    .dc_o  (dc_new)
  );

  assign skip_d = fire && dec.skip_en && (res == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      z_q     <= 1'b0;
      c_q     <= 1'b0;
      dc_q    <= 1'b0;
      valid_q <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      valid_q <= fire;
      skip_q  <= skip_d;
      if (fire) begin
        if (dec.wr_acc) acc_q <= res;
        if (dec.upd_z)  z_q   <= z_new;
        if (dec.upd_c)  c_q   <= c_new;
        if (dec.upd_dc) dc_q  <= dc_new;
      end
    end
  end

  assign acc_o       = acc_q;
  assign z_o         = z_q;
  assign c_o         = c_q;
  assign dc_o        = dc_q;
  assign valid_o     = valid_q;
  assign skip_next_o = skip_q;
endmodule

// File: rtl/acc_alu_core_chk.sv
module acc_alu_core_chk #(
  parameter int INSTR_W = 13,
  parameter int DATA_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               instr_valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic [DATA_W-1:0]  acc_o,
  input logic               z_o,
  input logic               c_o,
  input logic               dc_o,
  input logic               valid_o,
  input logic               skip_next_o
);
  logic take;
  assign take = instr_valid_i && !skip_next_o;

  AST_SKIP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_next_o |=> !skip_next_o); // R8
  AST_SKIP_AFTER_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_next_o |-> valid_o); // R8
  AST_SKIP_SQUASHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_next_o |=> !valid_o); // R8
  AST_DJZ_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && instr_i[INSTR_W-1:7] == 'd11) |=> $stable({z_o, c_o, dc_o})); // R8
  AST_MOVRA_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && instr_i[INSTR_W-1:6] == 'd1) |=> $stable({z_o, c_o, dc_o})); // R3
  AST_CLRA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && instr_i == 'h080) |=> (acc_o == '0 && z_o)); // R3
  AST_RRC_CARRY_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && instr_i[INSTR_W-1:6] == 'd24) |=> (acc_o[DATA_W-1] == $past(c_o))); // R9
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> valid_o); // R11
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> ($stable(acc_o) && $stable({z_o, c_o, dc_o}) && !valid_o)); // R11
endmodule

bind acc_alu_core acc_alu_core_chk #(.INSTR_W(INSTR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_i       (instr_i),
  .acc_o         (acc_o),
  .z_o           (z_o),
  .c_o           (c_o),
  .dc_o          (dc_o),
  .valid_o       (valid_o),
  .skip_next_o   (skip_next_o)
);

// File: tb/test_acc_alu_core.sv
`timescale 1ns/1ps
module test_acc_alu_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [12:0] instr_i = '0;
  logic [5:0]  dbg_addr_i = '0;
  logic [7:0]  acc_o, dbg_data_o;
  logic        z_o, c_o, dc_o, valid_o, skip_next_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk_i = ~clk_i;

  acc_alu_core i_acc_alu_core (
    .clk_i, .rst_ni, .instr_valid_i, .instr_i, .dbg_addr_i,
    .acc_o, .z_o, .c_o, .dc_o, .valid_o, .skip_next_o, .dbg_data_o
  );

  // {instr, acc, zcd, reg addr, reg value} after execution
  localparam int NV = 32;
  localparam logic [37:0] VEC [NV] = '{
    {13'h480, 8'hFF, 3'b000, 6'd0,  8'h00},  // R7 COMA
    {13'h041, 8'hFF, 3'b000, 6'd1,  8'hFF},  // R3 MOV R,A
    {13'h501, 8'h00, 3'b100, 6'd1,  8'hFF},  // R7 INCA
    {13'h541, 8'h00, 3'b100, 6'd1,  8'h00},  // R7 INC
    {13'h1C1, 8'h00, 3'b000, 6'd1,  8'hFF},  // R7 DEC
    {13'h381, 8'hFF, 3'b000, 6'd1,  8'hFF},  // R5 ADD A,R no carry
    {13'h3C1, 8'hFF, 3'b011, 6'd1,  8'hFE},  // R5 ADD R,A carry+dc
    {13'h101, 8'hFF, 3'b000, 6'd1,  8'hFE},  // R4 SUB borrow
    {13'h142, 8'hFF, 3'b000, 6'd2,  8'h01},  // R4 SUB R,A
    {13'h402, 8'h01, 3'b000, 6'd2,  8'h01},  // R7 MOV A,R
    {13'h101, 8'hFD, 3'b011, 6'd1,  8'hFE},  // R4 SUB no borrow
    {13'h401, 8'hFE, 3'b011, 6'd1,  8'hFE},  // R2 dest A
    {13'h141, 8'hFE, 3'b111, 6'd1,  8'h00},  // R4 SUB zero
    {13'h441, 8'hFE, 3'b111, 6'd1,  8'h00},  // R7 MOV R,R zero test
    {13'h4C1, 8'hFE, 3'b011, 6'd1,  8'hFF},  // R7 COM
    {13'h282, 8'h00, 3'b111, 6'd2,  8'h01},  // R6 AND A,R
    {13'h201, 8'hFF, 3'b011, 6'd1,  8'hFF},  // R6 OR A,R
    {13'h341, 8'hFF, 3'b111, 6'd1,  8'h00},  // R6 XOR R,A
    {13'h302, 8'hFE, 3'b011, 6'd2,  8'h01},  // R6 XOR A,R
    {13'h2C2, 8'hFE, 3'b111, 6'd2,  8'h00},  // R6 AND R,A
    {13'h242, 8'hFE, 3'b011, 6'd2,  8'hFE},  // R6 OR R,A
    {13'h602, 8'hFF, 3'b001, 6'd2,  8'hFE},  // R9 RRCA C=1 in
    {13'h602, 8'h7F, 3'b001, 6'd2,  8'hFE},  // R9 RRCA C=0 in
    {13'h080, 8'h00, 3'b101, 6'd2,  8'hFE},  // R3 CLRA
    {13'h0C2, 8'h00, 3'b101, 6'd2,  8'h00},  // R3 CLR R
    {13'h182, 8'hFF, 3'b001, 6'd2,  8'h00},  // R7 DECA
    {13'h000, 8'hFF, 3'b001, 6'd2,  8'h00},  // R10 NOP
    {13'h0A5, 8'hFF, 3'b001, 6'd37, 8'h00},  // R10 unused group 0
    {13'h7C3, 8'hFF, 3'b001, 6'd3,  8'h00},  // R10 group 7
    {13'h640, 8'hFF, 3'b001, 6'd0,  8'h00},  // R10 group 6 sub 1
    {13'h582, 8'hFF, 3'b001, 6'd2,  8'h00},  // R8 DJZA nonzero
    {13'h5C2, 8'hFF, 3'b001, 6'd2,  8'hFF}   // R8 DJZ nonzero
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [7:0] v);
    dbg_addr_i = a;
    #0.5;
    v = dbg_data_o;
  endtask

  task automatic step(input logic v, input logic [12:0] ins);
    instr_valid_i = v;
    instr_i       = ins;
    @(negedge clk_i);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 acc", acc_o, 8'h00);
    chk("R1 flags", {5'b0, z_o, c_o, dc_o}, 8'h00);
    chk("R1 valid/skip", {6'b0, valid_o, skip_next_o}, 8'h00);
    rd_reg(6'd63, rv); chk("R1 reg63", rv, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][37:25]);
      chk($sformatf("R2 vec%0d acc", i), acc_o, VEC[i][24:17]);
      chk($sformatf("R2 vec%0d flags", i), {5'b0, z_o, c_o, dc_o}, {5'b0, VEC[i][16:14]});
      chk($sformatf("R11 vec%0d valid/skip", i), {6'b0, valid_o, skip_next_o}, 8'h02);
      rd_reg(VEC[i][13:8], rv);
      chk($sformatf("R2 vec%0d reg", i), rv, VEC[i][7:0]);
    end

    // R8 DJZ to zero skips, next slot squashed
    step(1'b1, 13'h500);                       // A = 1
    step(1'b1, 13'h045);                       // r5 = 1
    step(1'b1, 13'h5C5);                       // r5 = 0, skip
    chk("R8 skip raised", {6'b0, valid_o, skip_next_o}, 8'h03);
    rd_reg(6'd5, rv); chk("R8 djz reg", rv, 8'h00);
    chk("R8 djz flags", {5'b0, z_o, c_o, dc_o}, 8'h01);
    step(1'b1, 13'h046);                       // squashed
    chk("R8 squashed valid/skip", {6'b0, valid_o, skip_next_o}, 8'h00);
    rd_reg(6'd6, rv); chk("R8 squashed reg", rv, 8'h00);
    step(1'b1, 13'h046);                       // r6 = 1
    rd_reg(6'd6, rv); chk("R8 after skip reg", rv, 8'h01);
    // R8 DJZA to zero: Z stays clear
    step(1'b1, 13'h586);
    chk("R8 djza acc", acc_o, 8'h00);
    chk("R8 djza flags", {5'b0, z_o, c_o, dc_o}, 8'h01);
    chk("R8 djza skip", {6'b0, valid_o, skip_next_o}, 8'h03);
    step(1'b0, 13'h000);
    chk("R8 skip one cycle", {6'b0, valid_o, skip_next_o}, 8'h00);
    // R11 idle slots hold
    step(1'b0, 13'h480);
    chk("R11 idle acc", acc_o, 8'h00);
    chk("R11 idle valid", {7'b0, valid_o}, 8'h00);
    rd_reg(6'd6, rv); chk("R11 idle reg", rv, 8'h01);

    // R1 reset mid-run
    step(1'b1, 13'h480);                       // A = FF
    rst_ni = 1'b0;
    #1;
    chk("R1 mid acc", acc_o, 8'h00);
    rd_reg(6'd6, rv); chk("R1 mid reg", rv, 8'h00);
    chk("R1 mid valid", {7'b0, valid_o}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule